// File: doc/BRIEF.md
# Tone-shift audio bit demodulator

This block turns a stream of signed audio samples into data bits. The samples carry two-tone frequency-shift keyed audio: 1200 Hz and 2200 Hz tones at 1200 bit/s, sampled at 9600 samples per second, so each bit spans eight samples. The block multiplies every sample by the sample taken half a bit earlier. A low-pass filter built only from shifts and adds smooths that product. The sign of the filter output is the instantaneous tone decision.

A phase counter sets the bit clock. It is pulled one step toward lock at every change of the tone decision, and it fires once per bit period. When it fires, a two-of-three vote over the latest decisions gives the raw line bit. The block then decodes that bit with the rule "no change is a one" and presents it with a single-cycle strobe to a downstream frame decoder.

Samples arrive with a valid strobe. Cycles without that strobe change nothing. The filter variant is chosen at build time by a parameter.

Top module: `afsk_rx_demod`

## Requirements
- R1: Each accepted sample s is multiplied by the sample accepted 4 samples before it, and the product is shifted right arithmetically by 2 (floor). Before 4 samples have been accepted since reset, the delayed operand is 0.
- R2: With `LPF_KIND = LPF_SHIFT3` the filter output becomes y' = p_prev + p + floor(y/2) + floor(y/8) + floor(y/32). Here p is the current product, p_prev is the product of the previous accepted sample and y is the previous output.
- R3: With `LPF_KIND = LPF_SHIFT1` the filter output becomes y' = p_prev + p + floor(y/2).
- R4: For each accepted sample, one decision bit enters a 3-deep decision history. The bit is 1 only when the new filter output is strictly greater than zero, so a zero output gives 0.
- R5: A phase counter (reset 0) adds 8 on every accepted sample. When the sum reaches 64 or more, 64 is subtracted and one output bit is produced. `bit_valid` is then high for exactly one cycle, the cycle after the clock edge that took that sample.
- R6: When the newest two decision bits differ, the counter first moves by 1 before the step of 8 is added: up if it is below 32, down otherwise.
- R7: The raw bit taken at each bit event is 1 when at least 2 of the 3 newest decision bits are 1.
- R8: `bit_data` is 1 when the current raw bit equals the previous raw bit, and 0 when they differ. The previous raw bit is 0 after reset.
- R9: Products and filter outputs saturate to the signed 16-bit range [-32768, 32767] instead of wrapping.
- R10: A synchronous reset, when high at a clock edge, clears the delay line, the filter state, the decision history, the phase counter, the previous raw bit and `bit_valid`. It overrides `smp_valid`.
- R11: A clock edge with `smp_valid` low changes no state, and `bit_valid` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | SAMP_W | Signed audio sample |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Decoded data bit |

## Verification
The bench builds two instances from the same stimulus. The first uses the default 8-bit samples with the three-shift filter. The second uses 12-bit samples with the single-shift filter, which puts both filter variants under test side by side. Full-scale input to the 12-bit instance drives the products far past 16 bits, so saturation of both the product and the filter can be reached. Neither can occur with 8-bit input. Square waves whose periods do not divide the bit period make the decision edges drift against the counter, which exercises the up and down nudges.

// File: rtl/afsk_rx_pkg.sv
`timescale 1ns/1ps
package afsk_rx_pkg;

  // Filter feedback variant
  typedef enum logic {
    LPF_SHIFT3 = 1'b0,  // feedback y/2 + y/8 + y/32
    LPF_SHIFT1 = 1'b1   // feedback y/2
  } lpf_kind_e;

  // Two-of-three vote over the newest decisions
  function automatic logic vote3(input logic [2:0] d);
    return (d[0] & d[1]) | (d[1] & d[2]) | (d[0] & d[2]);
  endfunction

  // Line decoding: a repeated level is a one
  function automatic logic nrzi_decode(input logic cur, input logic prev);
    return ~(cur ^ prev);
  endfunction

  // Change between the two newest decisions
  function automatic logic level_change(input logic [1:0] d);
    return d[1] ^ d[0];
  endfunction

endpackage

// File: rtl/afsk_delay_mixer.sv
`timescale 1ns/1ps
module afsk_delay_mixer #(
  parameter int SAMP_W    = 8,
  parameter int ACC_W     = 16,
  parameter int DELAY_LEN = 4,
  parameter int MIX_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_in,
  output logic signed [ACC_W-1:0]  mix_out
);

  localparam int WIDE_W = 32;
  localparam logic signed [WIDE_W-1:0] ACC_HI = (WIDE_W'(1) <<< (ACC_W - 1)) - 1;
  localparam logic signed [WIDE_W-1:0] ACC_LO = -(WIDE_W'(1) <<< (ACC_W - 1));

  function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [WIDE_W-1:0] v);
    if (v > ACC_HI)      return ACC_HI[ACC_W-1:0];
    else if (v < ACC_LO) return ACC_LO[ACC_W-1:0];
    else                 return v[ACC_W-1:0];
  endfunction

  function automatic logic signed [WIDE_W-1:0] mix_product(
    input logic signed [SAMP_W-1:0] a,
    input logic signed [SAMP_W-1:0] b
  );
    logic signed [WIDE_W-1:0] aw, bw;
    aw = WIDE_W'(a);
    bw = WIDE_W'(b);
    return (aw * bw) >>> MIX_SHIFT;
  endfunction

  logic signed [SAMP_W-1:0] taps [DELAY_LEN];
  logic signed [SAMP_W-1:0] delayed_smp;

  generate
    for (genvar g = 0; g < DELAY_LEN; g++) begin : g_tap
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)            taps[0] <= '0;
          else if (smp_valid) taps[0] <= smp_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)            taps[g] <= '0;
          else if (smp_valid) taps[g] <= taps[g-1];
        end
      end
    end
  endgenerate

  assign delayed_smp = taps[DELAY_LEN-1];
  assign mix_out     = sat_acc(mix_product(smp_in, delayed_smp));

  // R11
  mix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(delayed_smp));

  // R1
  mix_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_in > 0 && delayed_smp > 0) |-> mix_out >= 0);

  // R1
  mix_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (delayed_smp == 0) |-> mix_out == 0);

endmodule

// File: rtl/afsk_shift_lpf.sv
`timescale 1ns/1ps
module afsk_shift_lpf
  import afsk_rx_pkg::*;
#(
  parameter int        ACC_W    = 16,
  parameter lpf_kind_e LPF_KIND = LPF_SHIFT3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] x_in,
  output logic signed [ACC_W-1:0] y_next
);

  localparam int WIDE_W = 32;
  localparam logic signed [WIDE_W-1:0] ACC_HI = (WIDE_W'(1) <<< (ACC_W - 1)) - 1;
  localparam logic signed [WIDE_W-1:0] ACC_LO = -(WIDE_W'(1) <<< (ACC_W - 1));

  function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [WIDE_W-1:0] v);
    if (v > ACC_HI)      return ACC_HI[ACC_W-1:0];
    else if (v < ACC_LO) return ACC_LO[ACC_W-1:0];
    else                 return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0]  x_q;
  logic signed [ACC_W-1:0]  y_q;
  logic signed [WIDE_W-1:0] y_wide;
  logic signed [WIDE_W-1:0] feedback;
  logic signed [WIDE_W-1:0] raw_sum;

  assign y_wide = WIDE_W'(y_q);

  generate
    if (LPF_KIND == LPF_SHIFT3) begin : g_three
      assign feedback = (y_wide >>> 1) + (y_wide >>> 3) + (y_wide >>> 5);
    end else begin : g_one
      assign feedback = y_wide >>> 1;
    end
  endgenerate

  assign raw_sum = WIDE_W'(x_q) + WIDE_W'(x_in) + feedback;
  assign y_next  = sat_acc(raw_sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (en) begin
      x_q <= x_in;
      y_q <= y_next;
    end
  end

  // R11
  lpf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_q) && $stable(x_q));

  // R9
  lpf_sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (en && raw_sum > ACC_HI) |=> y_q == ACC_HI[ACC_W-1:0]);

  // R9
  lpf_sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (en && raw_sum < ACC_LO) |=> y_q == ACC_LO[ACC_W-1:0]);

endmodule

// File: rtl/afsk_bit_sync.sv
`timescale 1ns/1ps
module afsk_bit_sync
  import afsk_rx_pkg::*;
#(
  parameter int BIT_SAMPLES = 8,
  parameter int PHASE_STEP  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic level,
  output logic bit_valid,
  output logic bit_data
);

  localparam int PH_WRAP = BIT_SAMPLES * PHASE_STEP;
  localparam int PH_MID  = PH_WRAP / 2;
  localparam int PH_W    = $clog2(PH_WRAP + PHASE_STEP);

  logic [2:0]      dec_q;
  logic [2:0]      dec_next;
  logic            edge_w;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] ph_nudged;
  logic [PH_W-1:0] ph_sum;
  logic [PH_W-1:0] ph_next;
  logic            wrap_w;
  logic            raw_w;
  logic            raw_prev_q;

  assign dec_next = {dec_q[1:0], level};
  assign edge_w   = level_change(dec_next[1:0]);

  always_comb begin
    ph_nudged = phase_q;
    if (edge_w) begin
      if (phase_q < PH_W'(PH_MID)) ph_nudged = phase_q + PH_W'(1);
      else                         ph_nudged = phase_q - PH_W'(1);
    end
  end

  assign ph_sum  = ph_nudged + PH_W'(PHASE_STEP);
  assign wrap_w  = ph_sum >= PH_W'(PH_WRAP);
  assign ph_next = wrap_w ? ph_sum - PH_W'(PH_WRAP) : ph_sum;
  assign raw_w   = vote3(dec_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q      <= '0;
      phase_q    <= '0;
      raw_prev_q <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (en) begin
        dec_q   <= dec_next;
        phase_q <= ph_next;
        if (wrap_w) begin
          bit_valid  <= 1'b1;
          bit_data   <= nrzi_decode(raw_w, raw_prev_q);
          raw_prev_q <= raw_w;
        end
      end
    end
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q < PH_W'(PH_WRAP));

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !edge_w && (phase_q + PH_W'(PHASE_STEP) < PH_W'(PH_WRAP)))
    |=> phase_q == $past(phase_q) + PH_W'(PHASE_STEP));

  // R6
  nudge_up_chk: assert property (@(posedge clk) disable iff (rst)
    (en && edge_w && phase_q < PH_W'(PH_MID))
    |=> phase_q == $past(phase_q) + PH_W'(PHASE_STEP + 1));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> phase_q == '0 && !bit_valid && dec_q == '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bit_valid && $stable(phase_q) && $stable(dec_q));

endmodule

// File: rtl/afsk_rx_demod.sv
`timescale 1ns/1ps
module afsk_rx_demod
  import afsk_rx_pkg::*;
#(
  parameter int        SAMP_W      = 8,
  parameter int        ACC_W       = 16,
  parameter int        BIT_SAMPLES = 8,
  parameter int        PHASE_STEP  = 8,
  parameter int        MIX_SHIFT   = 2,
  parameter lpf_kind_e LPF_KIND    = LPF_SHIFT3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_in,
  output logic                     bit_valid,
  output logic                     bit_data
);

  localparam int DELAY_LEN = BIT_SAMPLES / 2;

  logic signed [ACC_W-1:0] mix_w;
  logic signed [ACC_W-1:0] lpf_w;
  logic                    tone_level;

  afsk_delay_mixer #(
    .SAMP_W    (SAMP_W),
    .ACC_W     (ACC_W),
    .DELAY_LEN (DELAY_LEN),
    .MIX_SHIFT (MIX_SHIFT)
  ) u_mixer (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_in    (smp_in),
    .mix_out   (mix_w)
  );

  afsk_shift_lpf #(
    .ACC_W    (ACC_W),
    .LPF_KIND (LPF_KIND)
  ) u_lpf (
    .clk    (clk),
    .rst    (rst),
    .en     (smp_valid),
    .x_in   (mix_w),
    .y_next (lpf_w)
  );

  assign tone_level = lpf_w > 0;

  afsk_bit_sync #(
    .BIT_SAMPLES (BIT_SAMPLES),
    .PHASE_STEP  (PHASE_STEP)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .en        (smp_valid),
    .level     (tone_level),
    .bit_valid (bit_valid),
    .bit_data  (bit_data)
  );

  // R4
  level_sign_chk: assert property (@(posedge clk) disable iff (rst)
    tone_level |-> lpf_w != 0);

endmodule

// File: tb/afsk_rx_demod_tb.sv
`timescale 1ns/1ps
module afsk_rx_demod_tb_top;
  import afsk_rx_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [7:0]  smp_a = '0;
  logic signed [11:0] smp_b = '0;
  logic va, da, vb, db;

  always #4 clk = ~clk;

  afsk_rx_demod dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_a),
    .bit_valid(va), .bit_data(da)
  );

  afsk_rx_demod #(.SAMP_W(12), .LPF_KIND(LPF_SHIFT1)) dut_b_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_b),
    .bit_valid(vb), .bit_data(db)
  );

  int checks = 0;
  int bad = 0;
  string last_tag = "R10";

  // reference state, lane 0 = three-shift 8-bit, lane 1 = one-shift 12-bit
  int ring [2][8];
  int seen [2];
  int xl [2];
  int yl [2];
  int ph [2];
  int dec [2];
  int rawp [2];
  int exp_v [2];
  int exp_d [2];

  function automatic int fdiv(input int a, input int k);
    if (a >= 0) return a / k;
    return -((-a + k - 1) / k);
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      seen[k] = 0; xl[k] = 0; yl[k] = 0; ph[k] = 0; dec[k] = 0;
      rawp[k] = 0; exp_v[k] = 0; exp_d[k] = 0;
      for (int i = 0; i < 8; i++) ring[k][i] = 0;
    end
  endtask

  task automatic model_step(input int k, input int s, input logic v);
    int d, p, y, ones, raw;
    exp_v[k] = 0;
    if (!v) return;
    d = (seen[k] >= 4) ? ring[k][(seen[k] - 4) % 8] : 0;
    ring[k][seen[k] % 8] = s;
    seen[k] = seen[k] + 1;
    p = clamp16(fdiv(s * d, 4));
    if (k == 0) y = xl[k] + p + fdiv(yl[k], 2) + fdiv(yl[k], 8) + fdiv(yl[k], 32);
    else        y = xl[k] + p + fdiv(yl[k], 2);
    y = clamp16(y);
    xl[k] = p;
    yl[k] = y;
    dec[k] = ((dec[k] * 2) + ((y > 0) ? 1 : 0)) % 8;
    if ((dec[k] % 2) != ((dec[k] / 2) % 2)) ph[k] = ph[k] + ((ph[k] < 32) ? 1 : -1);
    ph[k] = ph[k] + 8;
    if (ph[k] >= 64) begin
      ph[k] = ph[k] - 64;
      ones = (dec[k] % 2) + ((dec[k] / 2) % 2) + ((dec[k] / 4) % 2);
      raw = (ones >= 2) ? 1 : 0;
      exp_d[k] = (raw == rawp[k]) ? 1 : 0;
      rawp[k] = raw;
      exp_v[k] = 1;
    end
  endtask

  task automatic compare();
    logic av, ad;
    for (int k = 0; k < 2; k++) begin
      av = (k == 0) ? va : vb;
      ad = (k == 0) ? da : db;
      checks++;
      if (av !== exp_v[k][0]) begin
        bad++;
        $display("FAIL %s lane%0d bit_valid actual=%b expected=%0d", last_tag, k, av, exp_v[k]);
      end
      if (exp_v[k] == 1) begin
        checks++;
        if (ad !== exp_d[k][0]) begin
          bad++;
          $display("FAIL %s lane%0d bit_data actual=%b expected=%0d", last_tag, k, ad, exp_d[k]);
        end
      end
    end
  endtask

  task automatic tick(input logic r, input logic v, input int sa, input int sb, input string tag);
    @(negedge clk);
    compare();
    if (r) model_reset();
    else begin
      model_step(0, sa, v);
      model_step(1, sb, v);
    end
    rst = r; smp_valid = v; smp_a = 8'(sa); smp_b = 12'(sb);
    last_tag = tag;
  endtask

  real tone_ph = 0.0;
  logic tone_hi = 1'b0;
  int lfsr = 32'h1d3a;

  // mode 0 pseudo-random data, 1 all zeros, 2 all ones
  task automatic afsk_burst(input int nbits, input real amp, input int mode,
                            input int gap, input int scale_b, input string tag);
    int s;
    logic dbit;
    for (int b = 0; b < nbits; b++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      dbit = (mode == 0) ? lfsr[0] : (mode == 2);
      if (!dbit) tone_hi = ~tone_hi;
      for (int i = 0; i < 8; i++) begin
        s = $rtoi(amp * $sin(tone_ph));
        tone_ph = tone_ph + 2.0 * 3.14159265 * (tone_hi ? 2200.0 : 1200.0) / 9600.0;
        tick(1'b0, 1'b1, s, s * scale_b, tag);
        for (int g = 0; g < gap; g++) tick(1'b0, 1'b0, -s, s, tag);
      end
    end
  endtask

  task automatic square(input int n, input int period, input int hi, input int lo,
                        input int scale_b, input string tag);
    int s;
    for (int i = 0; i < n; i++) begin
      s = ((i % period) < (period / 2)) ? hi : lo;
      tick(1'b0, 1'b1, s, s * scale_b, tag);
    end
  endtask

  initial begin
    model_reset();
    // R10: reset state, reset wins over smp_valid
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 55, 55, "R10");
    // R11: no valid strobe, busy sample bus
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, i * 7 - 100, i, "R11");
    // R4: silent input gives zero filter output, decision 0
    square(48, 8, 0, 0, 1, "R4");
    // R1: half-bit alternating blocks give negative products
    square(64, 8, 50, -50, 1, "R1");
    // R2 and R3: tone stream, both filter lanes
    afsk_burst(120, 100.0, 0, 0, 1, "R2");
    afsk_burst(60, 60.0, 0, 0, 1, "R3");
    // R8: all-zero data toggles the tone every bit
    afsk_burst(40, 110.0, 1, 0, 1, "R8");
    // R7: all-one data holds one tone
    afsk_burst(40, 90.0, 2, 0, 1, "R7");
    // R6: square periods off the bit period make edges drift both ways
    square(200, 7, 80, -80, 1, "R6");
    square(200, 9, -70, 70, 1, "R6");
    square(150, 10, 90, -90, 1, "R6");
    // R11: gapped samples must match an ungapped reference
    afsk_burst(60, 100.0, 0, 2, 1, "R11");
    // R9: full-scale input, lane 1 pushed far past 16 bits
    square(120, 6, 127, -128, 16, "R9");
    afsk_burst(40, 127.0, 0, 0, 16, "R9");
    // R10: reset mid-stream then restart
    for (int i = 0; i < 2; i++) tick(1'b1, 1'b1, 99, 99, "R10");
    // R5: bit timing after restart
    afsk_burst(80, 100.0, 0, 0, 1, "R5");
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 0, 0, "R5");
    @(negedge clk);
    compare();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog run hung actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule